// File: doc/BRIEF.md
# Partial-Array Temperature-Compensated Self-Refresh Engine

This block is the refresh side of a four-bank low-power SDRAM device. It watches the command pins together with the clock enable. An extended mode register write stores two fields. One is a temperature code that sets how often rows are refreshed. The other is a coverage code that limits refresh to all banks, half of them or a single bank.

When the controller enters self refresh, a free-running interval timer starts. Its reload value depends on the stored temperature code. On each expiry the engine emits a one-cycle refresh strobe with a bank and a row. An internal counter supplies these and steps only through the covered banks. When clock enable rises again, the engine leaves self refresh. It then holds a busy flag for one refresh cycle time before it accepts commands again. The row position survives across self-refresh sessions, so refresh continues where it stopped.

Top module: `lpsr_refresh_engine`

## Requirements
- R1: After reset `busy_o` and `rfsh_vld_o` are low, the temperature code is 00 (70 °C interval) and the coverage code is 000 (all banks).
- R2: A mode-register-set pattern (CS, RAS, CAS, WE all low, CKE high this cycle and the previous one) with bank select 2'b10 and address bits 11..5 all zero stores address bits 4:3 as the temperature code and bits 2:0 as the coverage code. With bank select 2'b00, or with any of bits 11..5 set, both fields stay unchanged.
- R3: Self refresh starts when, in the idle state, CKE was high on the previous edge, is low on this edge, and CS, RAS and CAS are low with WE high. `busy_o` is high after that edge. The same pattern with CKE staying high, or CKE falling with a NOP, does not start it.
- R4: In self refresh the first strobe appears REFI cycles after the entry edge and then every REFI cycles. REFI is chosen by temperature code: 11 (85 °C) gives REFI_85, 00 (70 °C) gives REFI_70, 01 (45 °C) gives REFI_45, and 10 (15 °C) gives REFI_15. The values shrink as temperature rises.
- R5: Each strobe refreshes one bank. With coverage 000 the banks go 0,1,2,3. With 001 they go 0,1, which are the banks with BA1=0. With 010 only bank 0 is used. Reserved codes 011 to 111 act as 000. The bank sequence restarts at 0 on each entry.
- R6: The row advances by one after the last covered bank is refreshed, wraps from 4095 to 0, and keeps its value across exits and entries.
- R7: The row and bank on the strobes come only from the internal counter. The address and bank inputs during self refresh have no effect.
- R8: CKE high on an edge in self refresh ends it, and no strobe follows that edge. `busy_o` stays high for TRC edges counted from that exit edge and falls after the TRC-th.
- R9: A register write while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable from the controller |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BANK_W | Bank select |
| addr_i | input | ADDR_W | Address bus |
| rfsh_vld_o | output | 1 | One-cycle refresh strobe |
| rfsh_bank_o | output | BANK_W | Bank refreshed by the strobe |
| rfsh_row_o | output | ROW_W | Row refreshed by the strobe |
| busy_o | output | 1 | High in self refresh and exit recovery |

## Verification
The block keeps no per-bank state, so the checks assume self refresh is only entered while all banks are idle. They also assume the edge right after exit carries a NOP or deselect. The stimulus keeps to both rules: it always idles with NOPs before entry and issues NOPs or deselects right after exit. The only command placed inside recovery is a deliberate register write that must be ignored. The strobe-spacing property needs every interval reload of at least two cycles, and the bench parameters respect that.

// File: rtl/lpsr_pkg.sv
package lpsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SREF  = 2'd1,
        ST_RECOV = 2'd2
    } lpsr_state_e;

    // temperature codes (field position and values are decoded by the timer)
    localparam logic [1:0] TC_70 = 2'b00;
    localparam logic [1:0] TC_45 = 2'b01;
    localparam logic [1:0] TC_15 = 2'b10;
    localparam logic [1:0] TC_85 = 2'b11;

    // coverage codes; anything else falls back to full coverage
    localparam logic [2:0] COV_ALL     = 3'b000;
    localparam logic [2:0] COV_HALF    = 3'b001;
    localparam logic [2:0] COV_QUARTER = 3'b010;

    function automatic logic cmd_is_mrs(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        return !cs_n && !ras_n && !cas_n && !we_n;
    endfunction

    function automatic logic cmd_is_arf(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        return !cs_n && !ras_n && !cas_n && we_n;
    endfunction

endpackage

// File: rtl/lpsr_xmode_reg.sv
module lpsr_xmode_reg (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic [4:0] field_i,
    output logic [1:0] temp_o,
    output logic [2:0] cov_o
);
    import lpsr_pkg::*;

    typedef struct packed {
        logic [1:0] temp;
        logic [2:0] cov;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.temp = field_i[4:3];
            s_d.cov  = field_i[2:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{temp: TC_70, cov: COV_ALL};
        end else begin
            s_q <= s_d;
        end
    end

    assign temp_o = s_q.temp;
    assign cov_o  = s_q.cov;

endmodule

// File: rtl/lpsr_sref_timer.sv
module lpsr_sref_timer #(
    parameter int REFI_85 = 64,
    parameter int REFI_70 = 128,
    parameter int REFI_45 = 256,
    parameter int REFI_15 = 512
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic       run_i,
    input  logic [1:0] temp_i,
    output logic       tick_o
);
    import lpsr_pkg::*;

    localparam int MAX_A = (REFI_85 > REFI_70) ? REFI_85 : REFI_70;
    localparam int MAX_B = (REFI_45 > REFI_15) ? REFI_45 : REFI_15;
    localparam int TMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(TMAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             s_d, s_q;
    logic [CNT_W-1:0] reload_w;

    always_comb begin
        case (temp_i)
            TC_85:   reload_w = CNT_W'(REFI_85 - 1);
            TC_45:   reload_w = CNT_W'(REFI_45 - 1);
            TC_15:   reload_w = CNT_W'(REFI_15 - 1);
            default: reload_w = CNT_W'(REFI_70 - 1);
        endcase

        tick_o = run_i && !load_i && (s_q.cnt == '0);

        s_d = s_q;
        if (load_i) begin
            s_d.cnt = reload_w;
        end else if (run_i) begin
            s_d.cnt = (s_q.cnt == '0) ? reload_w : s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/lpsr_row_gen.sv
module lpsr_row_gen #(
    parameter int NBANK = 4,
    parameter int ROWS  = 4096,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic              adv_i,
    input  logic [2:0]        cov_i,
    output logic              vld_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o
);
    import lpsr_pkg::*;

    localparam logic [BANK_W-1:0] LAST_ALL  = BANK_W'(NBANK - 1);
    localparam logic [BANK_W-1:0] LAST_HALF = BANK_W'(NBANK / 2 - 1);
    localparam logic [BANK_W-1:0] LAST_QTR  = BANK_W'(NBANK / 4 - 1);
    localparam logic [ROW_W-1:0]  ROW_TOP   = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              vld;
        logic [BANK_W-1:0] out_bank;
        logic [ROW_W-1:0]  out_row;
    } rg_t;

    rg_t               s_d, s_q;
    logic [BANK_W-1:0] last_w;

    always_comb begin
        case (cov_i)
            COV_HALF:    last_w = LAST_HALF;
            COV_QUARTER: last_w = LAST_QTR;
            default:     last_w = LAST_ALL;
        endcase

        s_d     = s_q;
        s_d.vld = 1'b0;
        if (restart_i) begin
            s_d.bank = '0;
        end else if (adv_i) begin
            s_d.vld      = 1'b1;
            s_d.out_bank = s_q.bank;
            s_d.out_row  = s_q.row;
            if (s_q.bank >= last_w) begin
                s_d.bank = '0;
                s_d.row  = (s_q.row == ROW_TOP) ? '0 : s_q.row + 1'b1;
            end else begin
                s_d.bank = s_q.bank + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o  = s_q.vld;
    assign bank_o = s_q.out_bank;
    assign row_o  = s_q.out_row;

endmodule

// File: rtl/lpsr_refresh_engine.sv
module lpsr_refresh_engine
    import lpsr_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NBANK   = 4,
    parameter int ROWS    = 4096,
    parameter int REFI_85 = 64,
    parameter int REFI_70 = 128,
    parameter int REFI_45 = 256,
    parameter int REFI_15 = 512,
    parameter int TRC     = 8,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rfsh_vld_o,
    output logic [BANK_W-1:0] rfsh_bank_o,
    output logic [ROW_W-1:0]  rfsh_row_o,
    output logic              busy_o
);

    localparam int                RC_W    = $clog2(TRC);
    localparam logic [BANK_W-1:0] XMR_SEL = BANK_W'(2);

    typedef struct packed {
        lpsr_state_e     st;
        logic            cke;
        logic [RC_W-1:0] rcnt;
    } ctl_t;

    ctl_t        s_d, s_q;
    logic        enter_w, leave_w, xmr_wr_w, run_w, tick_w;
    logic [1:0]  temp_w;
    logic [2:0]  cov_w;
    lpsr_state_e state_w;

    always_comb begin
        enter_w  = (s_q.st == ST_IDLE) && s_q.cke && !cke_i
                   && cmd_is_arf(cs_n_i, ras_n_i, cas_n_i, we_n_i);
        leave_w  = (s_q.st == ST_SREF) && cke_i;
        xmr_wr_w = (s_q.st == ST_IDLE) && s_q.cke && cke_i
                   && cmd_is_mrs(cs_n_i, ras_n_i, cas_n_i, we_n_i)
                   && (ba_i == XMR_SEL) && (addr_i[ADDR_W-1:5] == '0);
        run_w    = (s_q.st == ST_SREF) && !cke_i;

        s_d     = s_q;
        s_d.cke = cke_i;
        case (s_q.st)
            ST_IDLE: begin
                if (enter_w) s_d.st = ST_SREF;
            end
            ST_SREF: begin
                if (leave_w) begin
                    s_d.st   = ST_RECOV;
                    s_d.rcnt = RC_W'(TRC - 1);
                end
            end
            ST_RECOV: begin
                if (s_q.rcnt == '0) s_d.st = ST_IDLE;
                else                s_d.rcnt = s_q.rcnt - 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, cke: 1'b0, rcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state_w = s_q.st;
    assign busy_o  = (s_q.st != ST_IDLE);

    lpsr_xmode_reg i_xmode_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (xmr_wr_w),
        .field_i (addr_i[4:0]),
        .temp_o  (temp_w),
        .cov_o   (cov_w)
    );

    lpsr_sref_timer #(
        .REFI_85 (REFI_85),
        .REFI_70 (REFI_70),
        .REFI_45 (REFI_45),
        .REFI_15 (REFI_15)
    ) i_sref_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (enter_w),
        .run_i  (run_w),
        .temp_i (temp_w),
        .tick_o (tick_w)
    );

    lpsr_row_gen #(
        .NBANK (NBANK),
        .ROWS  (ROWS)
    ) i_row_gen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (enter_w),
        .adv_i     (tick_w),
        .cov_i     (cov_w),
        .vld_o     (rfsh_vld_o),
        .bank_o    (rfsh_bank_o),
        .row_o     (rfsh_row_o)
    );

endmodule

// File: rtl/lpsr_refresh_engine_chk.sv
module lpsr_refresh_engine_chk
    import lpsr_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cke_i,
    input logic              busy_i,
    input logic              vld_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [2:0]        cov_i,
    input logic [1:0]        temp_i,
    input lpsr_state_e       st_i
);

    // R4: strobes only while the engine is busy in self refresh
    p_strobe_in_sref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i |-> busy_i);

    // R4: interval reloads are at least two cycles, so strobes never touch
    p_strobe_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i |=> !vld_i);

    // R5: half coverage never emits a bank with the top select bit set
    p_half_cover_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && cov_i == COV_HALF) |-> !bank_i[BANK_W-1]);

    // R5: quarter coverage only refreshes bank 0
    p_quarter_cover_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && cov_i == COV_QUARTER) |-> (bank_i == '0));

    // R8: a rising clock enable in self refresh leads to recovery with no strobe
    p_exit_recover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_SREF && cke_i) |=> (busy_i && !vld_i && st_i == ST_RECOV));

    // R9: configuration cannot change while busy
    p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> ($stable(temp_i) && $stable(cov_i)));

endmodule

bind lpsr_refresh_engine lpsr_refresh_engine_chk #(
    .BANK_W (BANK_W)
) i_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_i  (cke_i),
    .busy_i (busy_o),
    .vld_i  (rfsh_vld_o),
    .bank_i (rfsh_bank_o),
    .cov_i  (cov_w),
    .temp_i (temp_w),
    .st_i   (state_w)
);

// File: tb/test_lpsr_refresh_engine.sv
`timescale 1ns/1ps
module test_lpsr_refresh_engine;

    localparam int P85 = 4, P70 = 6, P45 = 8, P15 = 10, RC = 3;
    localparam int NROWS = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        vld, busy;
    logic [1:0]  bank;
    logic [11:0] row;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_row = 0;

    always #10 clk = ~clk;

    lpsr_refresh_engine #(
        .REFI_85 (P85), .REFI_70 (P70), .REFI_45 (P45), .REFI_15 (P15), .TRC (RC)
    ) i_lpsr_refresh_engine (
        .clk_i (clk), .rst_ni (rst_n), .cke_i (cke),
        .cs_n_i (cs_n), .ras_n_i (ras_n), .cas_n_i (cas_n), .we_n_i (we_n),
        .ba_i (ba), .addr_i (addr),
        .rfsh_vld_o (vld), .rfsh_bank_o (bank), .rfsh_row_o (row), .busy_o (busy)
    );

    // {temp[1:0], cov[2:0], strobes[7:0]}
    localparam logic [12:0] VEC [6] = '{
        {2'b11, 3'b000, 8'd6},
        {2'b00, 3'b001, 8'd5},
        {2'b01, 3'b010, 8'd3},
        {2'b10, 3'b000, 8'd5},
        {2'b11, 3'b101, 8'd5},
        {2'b00, 3'b111, 8'd4}
    };

    function automatic int period_of(input logic [1:0] t);
        case (t)
            2'b11:   return P85;
            2'b01:   return P45;
            2'b10:   return P15;
            default: return P70;
        endcase
    endfunction

    function automatic int last_of(input logic [2:0] c);
        case (c)
            3'b001:  return 1;
            3'b010:  return 0;
            default: return 3;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_cmd(input logic c, input logic [3:0] cmd,
                           input logic [1:0] b, input logic [11:0] a);
        cke = c;
        {cs_n, ras_n, cas_n, we_n} = cmd;
        ba = b;
        addr = a;
    endtask

    task automatic nop();
        set_cmd(1'b1, 4'b0111, 2'b00, 12'h000);
    endtask

    task automatic write_reg(input logic [1:0] b, input logic [11:0] a);
        set_cmd(1'b1, 4'b0000, b, a);
        tick();
        nop();
        tick();
    endtask

    // enter, collect n strobes, exit; optionally poke a register write in recovery
    task automatic run_sref(input logic [1:0] t, input logic [2:0] c, input int n,
                            input bit poke);
        int p = period_of(t);
        int lb = last_of(c);
        int bidx = 0;
        set_cmd(1'b0, 4'b0001, 2'b11, 12'hABC);
        tick();
        chk("R3", "busy after entry", int'(busy), 1);
        for (int k = 1; k <= n * p; k++) begin
            set_cmd(1'b0, 4'b1000, 2'(k), 12'(k * 37)); // junk on the buses: R7
            tick();
            chk("R4", "strobe timing", int'(vld), (k % p == 0) ? 1 : 0);
            if (k % p == 0) begin
                chk("R5", "strobe bank", int'(bank), bidx);
                chk("R6", "strobe row (R7 counter only)", int'(row), exp_row);
                if (bidx >= lb) begin
                    bidx = 0;
                    exp_row = (exp_row + 1) % NROWS;
                end else begin
                    bidx++;
                end
            end
        end
        nop();
        tick();
        chk("R8", "busy on exit edge", int'(busy), 1);
        chk("R8", "no strobe after exit", int'(vld), 0);
        for (int j = 1; j < RC; j++) begin
            if (poke && j == 2) set_cmd(1'b1, 4'b0000, 2'b10, 12'h010);
            else                nop();
            tick();
            chk("R8", "busy in recovery", int'(busy), 1);
            chk("R8", "no strobe in recovery", int'(vld), 0);
        end
        nop();
        tick();
        chk("R8", "busy released", int'(busy), 0);
        tick();
    endtask

    initial begin
        nop();
        tick();
        tick();
        chk("R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        tick();
        tick();
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "strobe after reset", int'(vld), 0);

        // R1 defaults: 70 C interval, all banks
        run_sref(2'b00, 3'b000, 5, 1'b0);

        // table walk: R2 programming, R4 intervals, R5 coverage, R6 row carry
        foreach (VEC[i]) begin
            write_reg(2'b10, {7'b0, VEC[i][12:11], VEC[i][10:8]});
            run_sref(VEC[i][12:11], VEC[i][10:8], int'(VEC[i][7:0]), 1'b0);
        end

        // R2: normal-register select and nonzero upper bits leave fields alone
        write_reg(2'b10, {7'b0, 2'b11, 3'b010});
        write_reg(2'b00, {7'b0, 2'b10, 3'b000});
        write_reg(2'b10, 12'h080 | {7'b0, 2'b01, 3'b000});
        run_sref(2'b11, 3'b010, 3, 1'b0);

        // R3: no entry on power-down pattern or on plain auto refresh
        set_cmd(1'b0, 4'b0111, 2'b00, 12'h000);
        tick();
        chk("R3", "busy after CKE drop with NOP", int'(busy), 0);
        set_cmd(1'b0, 4'b0001, 2'b00, 12'h000);
        tick();
        chk("R3", "busy with ARF while CKE already low", int'(busy), 0);
        nop();
        tick();
        set_cmd(1'b1, 4'b0001, 2'b00, 12'h000);
        tick();
        chk("R3", "busy after ARF with CKE high", int'(busy), 0);
        chk("R3", "no strobe outside self refresh", int'(vld), 0);
        nop();
        tick();

        // R9: write poked during recovery is dropped
        run_sref(2'b11, 3'b010, 2, 1'b1);
        run_sref(2'b11, 3'b010, 2, 1'b0);

        // R6: quarter coverage, shortest interval, run across the row wrap
        write_reg(2'b10, {7'b0, 2'b11, 3'b010});
        run_sref(2'b11, 3'b010, NROWS - exp_row + 2, 1'b0);
        chk("R6", "row model wrapped", exp_row, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule